// File: doc/BRIEF.md
# Sectioned Carry-Select Adder/Subtractor

This block adds or subtracts two W-bit operands and registers the result. Its datapath is a row of one-bit slices grouped into five-slice sections, and two sections form a ten-slice cluster. Each slice works out its sum and carry twice, at the same time. One copy assumes the carry coming in is 0 and the other assumes it is 1. Both carries pass on to the next slice and feed that slice's sum logic as well as its carry logic. A resolved carry exists only at the edge of each section, where it picks one of the two precomputed results. The critical path therefore runs through one selection point per five bits and not through every slice.

A per-operation control `sub` chooses the function. When it is high, B is inverted and a 1 is forced into the first slice of the chain, which forms A − B in two's complement. When it is low, the forced carry is 0 and the block forms A + B. The forced carry enters only the slice where the chain starts. The parameter `START` places that slice anywhere inside the first cluster. The total slice count is rounded up to a whole number of sections. The registered outputs are the result, the carry out of the top operand bit and a signed-overflow flag. The output register has an enable, a synchronous clear and a synchronous load, and clear has priority over load.

Top module: `csa_addsub`

## Requirements
- R1: With `rst`=0, `en`=1, `clr`=0, `ld`=0 and `sub`=0, `q` equals (a + b) mod 2^W on the clock edge after the inputs are applied.
- R2: With the same controls and `sub`=1, `q` equals (a − b) mod 2^W one cycle later.
- R3: `cout` registers the carry out of operand bit W−1. For an add it is 1 when a + b ≥ 2^W. For a subtract it is 1 when a ≥ b as unsigned numbers, that is, when no borrow occurs.
- R4: `ovf` is 1 when the result, read as a two's-complement number, does not equal the true signed sum or difference of a and b.
- R5: With `en`=1 and `clr`=1, the next cycle has `q`, `cout` and `ovf` all 0, whatever the values of `ld` and `sub`.
- R6: With `en`=1, `clr`=0 and `ld`=1, the next cycle has `q` = `ld_val` and `cout` = `ovf` = 0.
- R7: With `en`=0, the outputs keep their values, even when `clr`, `ld` or the operands change.
- R8: `rst`=1 at a clock edge sets all outputs to 0, regardless of `en`.
- R9: A carry or borrow that must ripple across every section gives exact results. Two cases show this: all-ones + 1 gives 0 with `cout`=1, and 0 − 1 gives all-ones with `cout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable for the output register |
| clr | input | 1 | Synchronous clear, highest priority while enabled |
| ld | input | 1 | Synchronous load of `ld_val` |
| sub | input | 1 | 1 = subtract, 0 = add |
| a | input | W | Operand A |
| b | input | W | Operand B |
| ld_val | input | W | Value taken by the load |
| q | output | W | Registered result |
| cout | output | 1 | Registered carry out of bit W−1 |
| ovf | output | 1 | Registered signed overflow |

## Verification
Random operand pairs, applied in both add and subtract mode, exercise the generic datapath. Overflow and carry-out each turn on and off across these pairs, which keeps the flags separate from the sum bits. Directed patterns drive carries across every selection point: all-ones + 1, 0 − 1, and a subtraction of equal operands. Together they show whether the resolved section carry picks the correct precomputed chain. Mixed sequences of enable, clear and load, with operands changing in the same cycle, separate the register priorities from the arithmetic path.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int SEG_W = 5;

  function automatic int padded_width(input int w, input int start);
    return ((w + start + 1 + SEG_W - 1) / SEG_W) * SEG_W;
  endfunction
endpackage

// File: rtl/csa_slice.sv
module csa_slice (
  input  logic a,
  input  logic b,
  input  logic ci0,
  input  logic ci1,
  output logic s0,
  output logic s1,
  output logic co0,
  output logic co1
);
  logic p, g;
  always_comb begin
    p   = a ^ b;
    g   = a & b;
    s0  = p ^ ci0;
    s1  = p ^ ci1;
    co0 = g | (p & ci0);
    co1 = g | (p & ci1);
  end
endmodule

// File: rtl/csa_segment.sv
module csa_segment #(
  parameter int SW        = 5,
  parameter int FORCE_POS = -1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          cin,
  input  logic          inj,
  output logic [SW-1:0] sum,
  output logic          cout
);
  logic [SW:0]   c0, c1;
  logic [SW-1:0] s0, s1;
  logic [SW-1:0] ci0, ci1;

  assign c0[0] = 1'b0;
  assign c1[0] = 1'b1;

  for (genvar i = 0; i < SW; i++) begin : g_bit
    if (i == FORCE_POS) begin : g_force
      assign ci0[i] = inj;
      assign ci1[i] = inj;
    end else begin : g_pair
      assign ci0[i] = c0[i];
      assign ci1[i] = c1[i];
    end
    csa_slice u_slice (
      .a  (a[i]),
      .b  (b[i]),
      .ci0(ci0[i]),
      .ci1(ci1[i]),
      .s0 (s0[i]),
      .s1 (s1[i]),
      .co0(c0[i+1]),
      .co1(c1[i+1])
    );
  end

  always_comb begin
    sum  = cin ? s1 : s0;
    cout = cin ? c1[SW] : c0[SW];
  end

  // R1: the carry for an assumed 1 is never below the one for an assumed 0
  a_r1_pair_order: assert property (@(posedge clk) disable iff (rst)
    ((c0[SW] & ~c1[SW]) == 1'b0));
endmodule

// File: rtl/csa_chain.sv
module csa_chain #(
  parameter int W     = 16,
  parameter int START = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  import csa_pkg::*;
  localparam int TOT  = padded_width(W, START);
  localparam int NSEG = TOT / SEG_W;

  logic [TOT-1:0]  a_pad, b_pad, s_pad, pad_mask;
  logic [W-1:0]    b_eff;
  logic [NSEG:0]   seg_c;

  always_comb begin
    b_eff    = b ^ {W{sub}};
    a_pad    = '0;
    b_pad    = '0;
    a_pad[START +: W] = a;
    b_pad[START +: W] = b_eff;
    pad_mask = '1;
    pad_mask[START +: W+1] = '0;
  end

  assign seg_c[0] = 1'b0;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int FP = (START >= k*SEG_W && START < (k+1)*SEG_W) ? START - k*SEG_W : -1;
    csa_segment #(.SW(SEG_W), .FORCE_POS(FP)) u_seg (
      .clk (clk),
      .rst (rst),
      .a   (a_pad[k*SEG_W +: SEG_W]),
      .b   (b_pad[k*SEG_W +: SEG_W]),
      .cin (seg_c[k]),
      .inj (sub),
      .sum (s_pad[k*SEG_W +: SEG_W]),
      .cout(seg_c[k+1])
    );
  end

  always_comb begin
    sum  = s_pad[START +: W];
    cout = s_pad[START + W];
    ovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end

  // R1, R2: the sectioned result matches plain arithmetic
  a_r1_chain_sum: assert property (@(posedge clk) disable iff (rst)
    ({cout, sum} == ({1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub})));
  // R3: slices outside the operand field carry nothing
  a_r3_pad_quiet: assert property (@(posedge clk) disable iff (rst)
    ((s_pad & pad_mask) == '0));
  // R9: the final section carry out is never set
  a_r9_top_carry: assert property (@(posedge clk) disable iff (rst)
    (seg_c[NSEG] == 1'b0));
endmodule

// File: rtl/csa_outreg.sv
module csa_outreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] sum,
  input  logic         sum_cout,
  input  logic         sum_ovf,
  output logic [W-1:0] q,
  output logic         q_cout,
  output logic         q_ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      q_cout <= 1'b0;
      q_ovf  <= 1'b0;
    end else if (en) begin
      if (clr) begin
        q      <= '0;
        q_cout <= 1'b0;
        q_ovf  <= 1'b0;
      end else if (ld) begin
        q      <= ld_val;
        q_cout <= 1'b0;
        q_ovf  <= 1'b0;
      end else begin
        q      <= sum;
        q_cout <= sum_cout;
        q_ovf  <= sum_ovf;
      end
    end
  end

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (en && clr) |=> (q == '0 && !q_cout && !q_ovf));
  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && ld) |=> (q == $past(ld_val) && !q_cout && !q_ovf));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> ($stable(q) && $stable(q_cout) && $stable(q_ovf)));
  a_r8_reset: assert property (@(posedge clk)
    rst |=> (q == '0 && !q_cout && !q_ovf));
endmodule

// File: rtl/csa_addsub.sv
module csa_addsub #(
  parameter int W     = 16,
  parameter int START = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic         ld,
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] sum;
  logic         sum_cout, sum_ovf;

  csa_chain #(.W(W), .START(START)) u_chain (
    .clk (clk),
    .rst (rst),
    .a   (a),
    .b   (b),
    .sub (sub),
    .sum (sum),
    .cout(sum_cout),
    .ovf (sum_ovf)
  );

  csa_outreg #(.W(W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .clr     (clr),
    .ld      (ld),
    .ld_val  (ld_val),
    .sum     (sum),
    .sum_cout(sum_cout),
    .sum_ovf (sum_ovf),
    .q       (q),
    .q_cout  (cout),
    .q_ovf   (ovf)
  );
endmodule

// File: tb/csa_addsub_test.sv
`timescale 1ns/1ps
module csa_addsub_test;
  localparam int W = 16;

  logic         clk = 0;
  logic         rst, en, clr, ld, sub;
  logic [W-1:0] a, b, ld_val;
  logic [W-1:0] q;
  logic         cout, ovf;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] m_q;
  logic         m_c, m_v;

  csa_addsub #(.W(W), .START(0)) uut (
    .clk(clk), .rst(rst), .en(en), .clr(clr), .ld(ld), .sub(sub),
    .a(a), .b(b), .ld_val(ld_val), .q(q), .cout(cout), .ovf(ovf)
  );

  always #2.5 clk = ~clk;

  task automatic model_edge();
    logic [W:0] s;
    if (rst) begin
      m_q = '0; m_c = 0; m_v = 0;
    end else if (en) begin
      if (clr) begin
        m_q = '0; m_c = 0; m_v = 0;
      end else if (ld) begin
        m_q = ld_val; m_c = 0; m_v = 0;
      end else if (!sub) begin
        s = {1'b0, a} + {1'b0, b};
        m_q = s[W-1:0]; m_c = s[W];
        m_v = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
      end else begin
        s = {1'b0, a} + {1'b0, ~b} + 1;
        m_q = s[W-1:0]; m_c = s[W];
        m_v = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
      end
    end
  endtask

  task automatic step(input logic r, e, c, l, s, input logic [W-1:0] va, vb, vl,
                      input string tag);
    @(negedge clk);
    rst = r; en = e; clr = c; ld = l; sub = s; a = va; b = vb; ld_val = vl;
    @(posedge clk);
    model_edge();
    #1;
    tests++;
    if (q !== m_q || cout !== m_c || ovf !== m_v) begin
      fails++;
      $display("FAIL %s: q=%h cout=%b ovf=%b expected q=%h cout=%b ovf=%b",
               tag, q, cout, ovf, m_q, m_c, m_v);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: expected run end, got timeout");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    rst = 1; en = 0; clr = 0; ld = 0; sub = 0; a = '0; b = '0; ld_val = '0;
    m_q = '0; m_c = 0; m_v = 0;
    step(1, 0, 0, 0, 0, 16'h1234, 16'h0001, 16'h0, "R8 reset");
    step(1, 1, 0, 1, 0, 16'h1234, 16'h0001, 16'hBEEF, "R8 reset over load");
    // R1 / R2 directed
    step(0, 1, 0, 0, 0, 16'h1234, 16'h4321, 16'h0, "R1 add");
    step(0, 1, 0, 0, 1, 16'h4321, 16'h1234, 16'h0, "R2 sub");
    // R9 corner cases
    step(0, 1, 0, 0, 0, 16'hFFFF, 16'h0001, 16'h0, "R9 ones plus one");
    step(0, 1, 0, 0, 1, 16'h0000, 16'h0001, 16'h0, "R9 zero minus one");
    step(0, 1, 0, 0, 1, 16'h5A5A, 16'h5A5A, 16'h0, "R3 equal sub no borrow");
    // R4 overflow
    step(0, 1, 0, 0, 0, 16'h7FFF, 16'h0001, 16'h0, "R4 pos overflow");
    step(0, 1, 0, 0, 1, 16'h8000, 16'h0001, 16'h0, "R4 neg overflow");
    step(0, 1, 0, 0, 0, 16'h8000, 16'h8000, 16'h0, "R4 R3 neg add overflow");
    // R6 / R5 / R7
    step(0, 1, 0, 1, 0, 16'hFFFF, 16'h0001, 16'hC0DE, "R6 load");
    step(0, 0, 1, 1, 1, 16'h0001, 16'h0002, 16'h1111, "R7 hold");
    step(0, 0, 0, 0, 0, 16'hFFFF, 16'hFFFF, 16'h2222, "R7 hold ops");
    step(0, 1, 1, 1, 0, 16'hFFFF, 16'h0001, 16'h3333, "R5 clear over load");
    step(0, 1, 0, 0, 0, 16'h7FFF, 16'h7FFF, 16'h0, "R1 before reset");
    step(1, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0, "R8 mid reset");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb, rl;
      int sel;
      ra = W'($urandom); rb = W'($urandom); rl = W'($urandom);
      sel = $urandom_range(0, 15);
      if (sel < 6)       step(0, 1, 0, 0, 0, ra, rb, rl, "R1 R3 R4 random add");
      else if (sel < 12) step(0, 1, 0, 0, 1, ra, rb, rl, "R2 R3 R4 random sub");
      else if (sel == 12) step(0, 1, 0, 1, ra[0], ra, rb, rl, "R6 random load");
      else if (sel == 13) step(0, 1, 1, rb[0], ra[0], ra, rb, rl, "R5 random clear");
      else if (sel == 14) step(0, 0, ra[1], rb[1], ra[0], ra, rb, rl, "R7 random hold");
      else               step(0, 1, 0, 0, ra[0], W'(0) - W'(1), W'(ra[0]), rl, "R9 random ripple");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule